// File: doc/BRIEF.md
# ISA I/O Address Decoder

This block turns an ISA I/O cycle into a device select for a peripheral that holds eight logical functions. Each function has its own base address, an enable bit and a window size written as a power of two. Six functions are legacy-style and look only at the low ten address bits. The other two, a wave codec and a control port, look at twelve. The decoder is purely combinational. A select rises as soon as the address is stable and a read or write strobe is low, and it stays high for the whole strobe.

A mode input adds a check on the top four address lines so that no function shows up again higher in the 64 KiB I/O space. Two functions, the CD-ROM and modem ports, share their pins with those address lines, so they are switched off while that mode is on. DMA cycles, which the bus marks with AEN high, never select anything. If two windows overlap, the output still has at most one bit set, picked by a fixed priority, and a separate flag reports the overlap.

Top module: `isa_io_decode`

## Requirements
- R1: A ten-bit function (index 0 to 5) is a candidate when sa[9:0] equals its base in every bit position at or above its window size.
- R2: A ten-bit function is never selected while sa[10] or sa[11] is 1.
- R3: A twelve-bit function (index 6 wave codec, 7 control) is a candidate when sa[11:0] equals its base in every bit position at or above its window size.
- R4: With wide_mode at 1, nothing is selected unless sa[15:12] is 0. With wide_mode at 0, sa[15:12] has no effect.
- R5: With wide_mode at 1, the CD-ROM (index 4) and modem (index 5) selects stay at 0.
- R6: Nothing is selected while aen is 1.
- R7: A select needs ior_n or iow_n at 0. With both strobes at 1, nothing is selected.
- R8: A function whose dev_en bit is 0 is never selected.
- R9: The window field of function i is dev_win[4i+3:4i] and holds log2 of the window size. Address bits below that position are not compared, and the base bits below it are ignored.
- R10: dev_sel has at most one bit set. When several functions are candidates, the lowest index wins: 0 synthesizer, 1 legacy sound, 2 game port, 3 MIDI UART, 4 CD-ROM, 5 modem, 6 wave codec, 7 control. sel_conflict is 1 exactly when two or more functions are candidates.
- R11: sel_valid is 1 exactly when some dev_sel bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used only to sample the embedded checks |
| rst_n | input | 1 | Active-low reset used only to disable the checks |
| sa | input | 16 | System address bus |
| aen | input | 1 | Address enable. When 1, the cycle is a DMA cycle |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| wide_mode | input | 1 | Adds the check that sa[15:12] is 0 |
| dev_en | input | 8 | Enable bit for each function |
| dev_base | input | 96 | Base address of each function, 12 bits per function: function i at [12i+11:12i] |
| dev_win | input | 32 | log2 of the window size, 4 bits per function: function i at [4i+3:4i] |
| dev_sel | output | 8 | Select for each function, at most one bit set |
| sel_valid | output | 1 | Some function is selected |
| sel_conflict | output | 1 | Two or more functions matched the cycle |

## Verification
The embedded checks run on every cycle and cover the blocking rules: AEN, idle strobes, a nonzero upper nibble in wide mode, the pin-shared functions in wide mode, ten-bit functions above the 1 KiB space, disabled functions, the one-hot output and the agreement between the flags and the selects. These checks cannot confirm that the correct function wins on an address that should match, that the window boundaries sit where the sizes put them, or that overlapping windows resolve in priority order. The bench's sweeps show those. It walks every 12-bit address under several upper nibbles, in both modes, for a spread-out setup and for an overlapping one, and compares the outputs with an arithmetic model of each window.

// File: rtl/isa_decode_pkg.sv
package isa_decode_pkg;

  // Logical function indices; lower index has higher select priority.
  typedef enum logic [2:0] {
    FN_SYNTH  = 3'd0,
    FN_LEGACY = 3'd1,
    FN_GAME   = 3'd2,
    FN_MIDI   = 3'd3,
    FN_CDROM  = 3'd4,
    FN_MODEM  = 3'd5,
    FN_WAVE   = 3'd6,
    FN_CTRL   = 3'd7
  } fn_id_e;

  localparam int unsigned FN_COUNT  = 8;
  localparam int unsigned NARROW_AW = 10;
  localparam int unsigned FULL_AW   = 12;
  localparam int unsigned BUS_AW    = 16;
  localparam int unsigned WINSZ_W   = 4;

  // Functions that compare the full 12-bit space.
  localparam logic [FN_COUNT-1:0] FULL_CMP_SET = 8'b1100_0000;
  // Functions whose pins carry the upper address nibble in wide mode.
  localparam logic [FN_COUNT-1:0] PIN_SHARED_SET = 8'b0011_0000;

endpackage

// File: rtl/isa_cycle_qual.sv
module isa_cycle_qual #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned FULL_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BUS_W-1:0]     sa,
  input  logic                 aen,
  input  logic                 ior_n,
  input  logic                 iow_n,
  input  logic                 wide_mode,
  output logic                 cycle_ok,
  output logic                 upper_ok
);

  localparam int unsigned HI_W = BUS_W - FULL_W;

  logic [HI_W-1:0] sa_hi;
  logic            strobe_act;

  always_comb begin
    sa_hi      = sa[BUS_W-1:FULL_W];
    strobe_act = ~ior_n | ~iow_n;
    cycle_ok   = strobe_act & ~aen;
    upper_ok   = ~wide_mode | ~|sa_hi;
  end

  // R6: a DMA cycle never qualifies
  a_r6_dma_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !cycle_ok);
  // R7: idle strobes never qualify
  a_r7_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ior_n && iow_n) |-> !cycle_ok);
  // R4: narrow mode ignores the upper nibble
  a_r4_narrow_ignores_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> upper_ok);

endmodule

// File: rtl/isa_dev_match.sv
module isa_dev_match #(
  parameter int unsigned CMP_W  = 10,
  parameter int unsigned FULL_W = 12,
  parameter int unsigned WIN_W  = 4
) (
  input  logic [FULL_W-1:0] addr,
  input  logic [FULL_W-1:0] base,
  input  logic [WIN_W-1:0]  win_log2,
  input  logic              en,
  output logic              hit
);

  logic [CMP_W-1:0] cmp_mask;
  logic [CMP_W-1:0] diff;
  logic             alias_ok;

  always_comb begin
    for (int b = 0; b < CMP_W; b++) begin
      cmp_mask[b] = (int'(win_log2) <= b);
    end
    diff = (addr[CMP_W-1:0] ^ base[CMP_W-1:0]) & cmp_mask;
  end

  generate
    if (CMP_W < FULL_W) begin : g_narrow
      // Narrow decoders demand zero in the bits they do not compare.
      always_comb alias_ok = ~|addr[FULL_W-1:CMP_W];
    end else begin : g_full
      always_comb alias_ok = 1'b1;
    end
  endgenerate

  always_comb hit = en & alias_ok & ~|diff;

endmodule

// File: rtl/isa_prio_pick.sv
module isa_prio_pick #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any,
  output logic         multi
);

  logic [N-1:0] seen;

  always_comb begin
    seen[0] = 1'b0;
    for (int i = 1; i < N; i++) begin
      seen[i] = seen[i-1] | req[i-1];
    end
    gnt   = req & ~seen;
    any   = |req;
    multi = |(req & seen);
  end

  // R10: at most one grant, and only to a requester
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r10_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r10_multi_count: assert property (@(posedge clk) disable iff (!rst_n)
    multi == ($countones(req) > 1));
  a_r11_any_grant: assert property (@(posedge clk) disable iff (!rst_n)
    any == (gnt != '0));

endmodule

// File: rtl/isa_io_decode.sv
module isa_io_decode
  import isa_decode_pkg::*;
#(
  parameter int unsigned NUM_DEV  = FN_COUNT,
  parameter int unsigned NARROW_W = NARROW_AW,
  parameter int unsigned FULL_W   = FULL_AW,
  parameter int unsigned BUS_W    = BUS_AW,
  parameter int unsigned WIN_W    = WINSZ_W,
  parameter logic [NUM_DEV-1:0] WIDE_SET   = FULL_CMP_SET,
  parameter logic [NUM_DEV-1:0] SHARED_SET = PIN_SHARED_SET
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BUS_W-1:0]          sa,
  input  logic                      aen,
  input  logic                      ior_n,
  input  logic                      iow_n,
  input  logic                      wide_mode,
  input  logic [NUM_DEV-1:0]        dev_en,
  input  logic [NUM_DEV*FULL_W-1:0] dev_base,
  input  logic [NUM_DEV*WIN_W-1:0]  dev_win,
  output logic [NUM_DEV-1:0]        dev_sel,
  output logic                      sel_valid,
  output logic                      sel_conflict
);

  logic               cycle_ok;
  logic               upper_ok;
  logic [NUM_DEV-1:0] raw_hit;
  logic [NUM_DEV-1:0] cand;

  isa_cycle_qual #(.BUS_W(BUS_W), .FULL_W(FULL_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .sa        (sa),
    .aen       (aen),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .wide_mode (wide_mode),
    .cycle_ok  (cycle_ok),
    .upper_ok  (upper_ok)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    localparam int unsigned CW = WIDE_SET[i] ? FULL_W : NARROW_W;
    isa_dev_match #(.CMP_W(CW), .FULL_W(FULL_W), .WIN_W(WIN_W)) u_match (
      .addr     (sa[FULL_W-1:0]),
      .base     (dev_base[i*FULL_W +: FULL_W]),
      .win_log2 (dev_win[i*WIN_W +: WIN_W]),
      .en       (dev_en[i]),
      .hit      (raw_hit[i])
    );
  end

  always_comb begin
    cand = raw_hit & ~({NUM_DEV{wide_mode}} & SHARED_SET);
    cand = cand & {NUM_DEV{cycle_ok & upper_ok}};
  end

  isa_prio_pick #(.N(NUM_DEV)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cand),
    .gnt   (dev_sel),
    .any   (sel_valid),
    .multi (sel_conflict)
  );

  // R6: no select during a DMA cycle
  a_r6_no_sel_dma: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> dev_sel == '0);
  // R7: no select without a strobe
  a_r7_no_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ior_n && iow_n) |-> dev_sel == '0);
  // R4: wide mode blocks a nonzero upper nibble
  a_r4_upper_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && sa[BUS_W-1:FULL_W] != '0) |-> dev_sel == '0);
  // R5: pin-shared functions are off in wide mode
  a_r5_shared_off: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> (dev_sel & SHARED_SET) == '0);
  // R2: ten-bit functions never answer above the 1 KiB space
  a_r2_narrow_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (sa[FULL_W-1:NARROW_W] != '0) |-> (dev_sel & ~WIDE_SET) == '0);
  // R8: disabled functions are never selected
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel & ~dev_en) == '0);
  // R10: a conflict implies a valid select
  a_r10_conflict_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sel_conflict |-> sel_valid);

endmodule

// File: tb/tb_isa_io_decode.sv
module tb_isa_io_decode;

  logic        clk;
  logic        rst_n;
  logic [15:0] sa;
  logic        aen, ior_n, iow_n, wide_mode;
  logic [7:0]  dev_en;
  logic [95:0] dev_base;
  logic [31:0] dev_win;
  logic [7:0]  dev_sel;
  logic        sel_valid, sel_conflict;

  logic [11:0] bb [8];
  int          wl [8];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  isa_io_decode dut (
    .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .ior_n(ior_n),
    .iow_n(iow_n), .wide_mode(wide_mode), .dev_en(dev_en),
    .dev_base(dev_base), .dev_win(dev_win), .dev_sel(dev_sel),
    .sel_valid(sel_valid), .sel_conflict(sel_conflict)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      dev_base[i*12 +: 12] = bb[i];
      dev_win[i*4 +: 4]    = 4'(wl[i]);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] gs, logic [7:0] es,
                     logic gv, logic ev, logic gc, logic ec);
    checks++;
    if (gs !== es || gv !== ev || gc !== ec) begin
      fails++;
      $display("FAIL %s sa=%h wide=%0b: actual sel=%b v=%b c=%b expected sel=%b v=%b c=%b",
               tag, sa, wide_mode, gs, gv, gc, es, ev, ec);
    end
  endtask

  // Arithmetic model of the requirements.
  task automatic model(output logic [7:0] es, output logic ev, output logic ec);
    int a12, nib, span, win, n;
    logic [7:0] m;
    a12 = int'(sa[11:0]);
    nib = int'(sa[15:12]);
    n = 0;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      span = (i >= 6) ? 4096 : 1024;
      win  = 1 << wl[i];
      if (dev_en[i] && !aen && (!ior_n || !iow_n) &&
          (!wide_mode || nib == 0) && !(wide_mode && (i == 4 || i == 5)) &&
          (i >= 6 || a12 < 1024) &&
          ((a12 % span) / win == (int'(bb[i]) % span) / win)) begin
        m[i] = 1'b1;
        n++;
      end
    end
    es = '0;
    for (int i = 7; i >= 0; i--) if (m[i]) es = 8'(1) << i;
    ev = (n > 0);
    ec = (n > 1);
  endtask

  task automatic drive(logic [15:0] a, logic w, logic ae, logic rn, logic wn);
    @(negedge clk);
    sa = a; wide_mode = w; aen = ae; ior_n = rn; iow_n = wn;
    #5;
  endtask

  task automatic sweep(string tag, logic w, logic [3:0] nib, logic ae,
                       logic rn, logic wn, int lo, int hi);
    logic [7:0] es;
    logic ev, ec;
    for (int a = lo; a <= hi; a++) begin
      drive({nib, 12'(a)}, w, ae, rn, wn);
      model(es, ev, ec);
      chk(tag, dev_sel, es, sel_valid, ev, sel_conflict, ec);
    end
  endtask

  task automatic cfg_spread();
    bb[0] = 12'h388; wl[0] = 2;
    bb[1] = 12'h220; wl[1] = 4;
    bb[2] = 12'h200; wl[2] = 3;
    bb[3] = 12'h330; wl[3] = 1;
    bb[4] = 12'h1E0; wl[4] = 4;
    bb[5] = 12'h3F8; wl[5] = 3;
    bb[6] = 12'h534; wl[6] = 2;
    bb[7] = 12'h120; wl[7] = 3;
    dev_en = 8'hFF;
  endtask

  task automatic cfg_overlap();
    bb[0] = 12'h380; wl[0] = 4;
    bb[1] = 12'h388; wl[1] = 0;
    bb[2] = 12'h38A; wl[2] = 2;
    bb[3] = 12'h388; wl[3] = 0;
    bb[4] = 12'h388; wl[4] = 0;
    bb[5] = 12'h388; wl[5] = 3;
    bb[6] = 12'h38F; wl[6] = 3;
    bb[7] = 12'h000; wl[7] = 12;
    dev_en = 8'b1100_0111;
  endtask

  initial begin
    rst_n = 1'b0;
    sa = '0; aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1; wide_mode = 1'b0;
    cfg_spread();
    repeat (3) @(posedge clk);
    #5;
    chk("reset R7", dev_sel, 8'h00, sel_valid, 1'b0, sel_conflict, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed checks, spread configuration
    drive(16'h0388, 0, 0, 0, 1); chk("R1 synth base",   dev_sel, 8'h01, sel_valid, 1, sel_conflict, 0);
    drive(16'h038B, 0, 0, 0, 1); chk("R9 window top",   dev_sel, 8'h01, sel_valid, 1, sel_conflict, 0);
    drive(16'h038C, 0, 0, 0, 1); chk("R9 window past",  dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h0788, 0, 0, 0, 1); chk("R2 a10 alias",    dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h0B88, 0, 0, 0, 1); chk("R2 a11 alias",    dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h0536, 0, 0, 1, 0); chk("R3 wave codec",   dev_sel, 8'h40, sel_valid, 1, sel_conflict, 0);
    drive(16'h0D34, 0, 0, 1, 0); chk("R3 a11 compared", dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h1388, 0, 0, 0, 1); chk("R4 narrow hi",    dev_sel, 8'h01, sel_valid, 1, sel_conflict, 0);
    drive(16'h1388, 1, 0, 0, 1); chk("R4 wide hi",      dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h01E5, 0, 0, 0, 1); chk("R5 cdrom narrow", dev_sel, 8'h10, sel_valid, 1, sel_conflict, 0);
    drive(16'h01E5, 1, 0, 0, 1); chk("R5 cdrom wide",   dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h03FA, 1, 0, 0, 1); chk("R5 modem wide",   dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h0388, 0, 1, 0, 1); chk("R6 dma cycle",    dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    drive(16'h0388, 0, 0, 1, 1); chk("R7 no strobe",    dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    dev_en = 8'hFE;
    drive(16'h0388, 0, 0, 0, 1); chk("R8 disabled",     dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);
    dev_en = 8'hFF;
    drive(16'h0333, 0, 0, 0, 1); chk("R11 none",        dev_sel, 8'h00, sel_valid, 0, sel_conflict, 0);

    // Sweeps, spread configuration
    sweep("R1/R2/R3/R9/R11 narrow nib0", 0, 4'h0, 0, 0, 1, 0, 4095);
    sweep("R4 narrow nib5",              0, 4'h5, 0, 1, 0, 0, 4095);
    sweep("R4 narrow nibF",              0, 4'hF, 0, 0, 0, 0, 4095);
    sweep("R5/R9 wide nib0",             1, 4'h0, 0, 0, 1, 0, 4095);
    sweep("R4 wide nib1",                1, 4'h1, 0, 0, 1, 0, 4095);
    sweep("R4 wide nib8",                1, 4'h8, 0, 1, 0, 0, 4095);
    sweep("R4 wide nibF",                1, 4'hF, 0, 0, 1, 0, 4095);
    sweep("R6 dma sweep",                0, 4'h0, 1, 0, 0, 0, 1023);
    sweep("R7 idle sweep",               1, 4'h0, 0, 1, 1, 0, 1023);
    dev_en = 8'h00;
    sweep("R8 all off",                  0, 4'h0, 0, 0, 1, 0, 1023);

    // Overlapping configuration
    cfg_overlap();
    drive(16'h0388, 0, 0, 0, 1); chk("R10 synth wins",  dev_sel, 8'h01, sel_valid, 1, sel_conflict, 1);
    drive(16'h0000, 0, 0, 0, 1); chk("R10 ctrl alone",  dev_sel, 8'h80, sel_valid, 1, sel_conflict, 0);
    drive(16'h0392, 0, 0, 0, 1); chk("R10 ctrl lowest", dev_sel, 8'h80, sel_valid, 1, sel_conflict, 0);
    drive(16'h0389, 0, 0, 0, 1); chk("R10 pair",        dev_sel, 8'h01, sel_valid, 1, sel_conflict, 1);
    sweep("R10/R8 overlap narrow", 0, 4'h0, 0, 0, 1, 0, 4095);
    sweep("R10/R5 overlap wide",   1, 4'h0, 0, 1, 0, 0, 4095);
    sweep("R10/R4 overlap wide hi", 1, 4'h2, 0, 0, 1, 0, 1023);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule